// File: doc/BRIEF.md
# Multi-Mode Serial Shift Interface

This block is a small serial engine: an 8-bit shift register, a 4-bit edge counter and two sticky status flags. It serves three pins: a data/SDA pin, a clock/SCL pin and a data-out pin. A 2-bit wire-mode field selects how the block drives the pins:
- Mode 00 is off: the pins act as ordinary port I/O.
- Mode 01 is three-wire: the shift register feeds the data-out pin.
- Mode 10 and mode 11 are two-wire: the data and clock pins become open-drain, and the clock line is held low by hardware after a start condition.
- Mode 11 also holds the clock line low after a counter overflow.

Software uses a register port with four addresses:
- Address 0 is control: the wire mode in bits [5:4], and a clock-toggle strobe in bit 0.
- Address 1 is the shift register.
- Address 2 is status: the start flag in bit 7, the overflow flag in bit 6, and the counter in bits [3:0].
- Address 3 holds the pins: the direction bits in [6:4] and the port bits in [2:0], with pin 0 = data/SDA, pin 1 = clock/SCL and pin 2 = data-out.

Pad inputs pass through a synchroniser before any edge is detected. A counter wrap and a start condition each set a flag. Software clears a flag by writing one to it, and that write also releases the clock line that the flag was holding.

Top module: `wire_mode_shifter`

## Requirements
- R1: After reset, all four registers read 0x00 and no pad is driven (pad_oe = 0, pad_pullup = 0).
- R2: In mode 00, pad_out equals the port bits, pad_oe equals the direction bits, and pad_pullup equals port & ~dir. Clock-pin edges neither shift nor count, and no start flag is raised.
- R3: In mode 01, pad_out[2] is bit 7 of the shift register and pad_oe[2] is dir[2]. Pins 0 and 1 behave as in mode 00.
- R4: In modes 10 and 11, pin 0 is open-drain: pad_out[0] = 0, and pad_oe[0] = dir[0] & ~(shift bit 7 & port[0]). pad_pullup[1:0] is 0, and pin 2 behaves as in mode 00.
- R5: In modes 10 and 11, pad_out[1] = 0 and pad_oe[1] = dir[1] & (~port[1] | hold). Hold is the start flag, and in mode 11 also the overflow flag.
- R6: In any mode except 00, a synchronised falling edge on pin 0 while pin 1 is high sets the start flag (status bit 7).
- R7: In any mode except 00, each synchronised edge of pin 1 (rising or falling) increments the counter. A wrap from 15 to 0 sets the overflow flag (status bit 6). A status write loads the counter from bits [3:0].
- R8: In any mode except 00, each rising edge of pin 1 shifts pin 0 into bit 0, so data enters MSB first. A write to address 1 loads the shift register.
- R9: A status write that sets bit 7 or bit 6 clears the matching flag. A write with that bit at 0 leaves the flag as it is.
- R10: A control write with bit 0 set toggles port[1]. Bit 0 of control always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| pad_in | input | 3 | Pad input levels |
| pad_out | output | 3 | Pad output levels |
| pad_oe | output | 3 | Pad output enables |
| pad_pullup | output | 3 | Pad pull-up enables |

## Verification
The bench uses the default parameters: an 8-bit shift register, a 4-bit counter and a two-stage synchroniser. With these values, a full byte of 16 clock-pin edges drives the counter through its wrap and sets the overflow flag. The bench also preloads the counter to 15, so that a single edge reaches the wrap boundary. The short synchroniser keeps each pin step to a few cycles, which leaves room to test every mode's pin mapping through a vector table.

// File: rtl/wms_pkg.sv
package wms_pkg;
    typedef enum logic [1:0] {
        WM_OFF     = 2'b00,
        WM_THREE   = 2'b01,
        WM_TWO     = 2'b10,
        WM_TWO_OVF = 2'b11
    } wire_mode_e;

    localparam int NUM_PINS = 3;
    localparam int PIN_DAT  = 0;
    localparam int PIN_CLK  = 1;
    localparam int PIN_DOUT = 2;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_PINS = 2'd3;

    typedef struct packed {
        wire_mode_e          mode;
        logic [NUM_PINS-1:0] port;
        logic [NUM_PINS-1:0] dir;
    } regs_t;
endpackage

// File: rtl/wms_sync.sv
module wms_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // Lines idle high, so reset to ones to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '1;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wms_core.sv
module wms_core
    import wms_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wire_mode_e        mode,
    input  logic              dat_in,
    input  logic              clk_in,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              stat_wr,
    input  logic              clr_start,
    input  logic              clr_ovf,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [DATA_W-1:0] shreg,
    output logic [CNT_W-1:0]  cnt,
    output logic              start_flag,
    output logic              ovf_flag
);
    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              start;
        logic              ovf;
        logic              dat_prev;
        logic              clk_prev;
    } core_t;

    core_t core_d, core_q;
    logic  active, clk_rise, clk_fall, clk_edge, start_evt, wrap_evt;

    always_comb begin
        active    = (mode != WM_OFF);
        clk_rise  = clk_in & ~core_q.clk_prev;
        clk_fall  = ~clk_in & core_q.clk_prev;
        clk_edge  = active & (clk_rise | clk_fall);
        start_evt = active & core_q.dat_prev & ~dat_in & clk_in;
        wrap_evt  = clk_edge & (core_q.cnt == {CNT_W{1'b1}});

        core_d          = core_q;
        core_d.dat_prev = dat_in;
        core_d.clk_prev = clk_in;

        if (active && clk_rise) core_d.shreg = {core_q.shreg[DATA_W-2:0], dat_in};
        if (data_wr)            core_d.shreg = data_wdata;

        if (clk_edge) core_d.cnt = core_q.cnt + 1'b1;
        if (stat_wr)  core_d.cnt = cnt_wdata;

        // Clear first, then let a same-cycle event win.
        if (stat_wr && clr_start) core_d.start = 1'b0;
        if (start_evt)            core_d.start = 1'b1;
        if (stat_wr && clr_ovf)   core_d.ovf   = 1'b0;
        if (wrap_evt)             core_d.ovf   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q          <= '0;
            core_q.dat_prev <= 1'b1;
            core_q.clk_prev <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    assign shreg      = core_q.shreg;
    assign cnt        = core_q.cnt;
    assign start_flag = core_q.start;
    assign ovf_flag   = core_q.ovf;

    assert_mode_off_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_OFF && !data_wr) |=> $stable(core_q.shreg));

    assert_start_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.start) |-> ($past(mode) != WM_OFF));

    assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> core_q.ovf);

    assert_clear_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && clr_start && !start_evt) |=> !core_q.start);
endmodule

// File: rtl/wms_pad.sv
module wms_pad
    import wms_pkg::*;
(
    input  wire_mode_e          mode,
    input  logic [NUM_PINS-1:0] port,
    input  logic [NUM_PINS-1:0] dir,
    input  logic                sh_msb,
    input  logic                hold,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pullup
);
    always_comb begin
        pad_out    = port;
        pad_oe     = dir;
        pad_pullup = port & ~dir;
        case (mode)
            WM_THREE: pad_out[PIN_DOUT] = sh_msb;
            WM_TWO, WM_TWO_OVF: begin
                pad_out[PIN_DAT]    = 1'b0;
                pad_out[PIN_CLK]    = 1'b0;
                pad_oe[PIN_DAT]     = dir[PIN_DAT] & ~(sh_msb & port[PIN_DAT]);
                pad_oe[PIN_CLK]     = dir[PIN_CLK] & (~port[PIN_CLK] | hold);
                pad_pullup[PIN_DAT] = 1'b0;
                pad_pullup[PIN_CLK] = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wire_mode_shifter.sv
module wire_mode_shifter
    import wms_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [2:0]        pad_in,
    output logic [2:0]        pad_out,
    output logic [2:0]        pad_oe,
    output logic [2:0]        pad_pullup
);
    localparam int STROBE_BIT = 0;
    localparam int MODE_LSB   = 4;
    localparam int DIR_LSB    = 4;
    localparam int START_BIT  = DATA_W - 1;
    localparam int OVF_BIT    = DATA_W - 2;
    localparam int STAT_PAD   = DATA_W - 2 - CNT_W;

    regs_t regs_d, regs_q;

    logic [1:0]        sync_pins;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              start_flag, ovf_flag, hold;
    logic              wr_ctrl, wr_data, wr_stat, wr_pins;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_pins = reg_wr && (reg_addr == ADDR_PINS);

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.mode = wire_mode_e'(reg_wdata[MODE_LSB +: 2]);
            if (reg_wdata[STROBE_BIT]) regs_d.port[PIN_CLK] = ~regs_q.port[PIN_CLK];
        end
        if (wr_pins) begin
            regs_d.port = reg_wdata[0 +: NUM_PINS];
            regs_d.dir  = reg_wdata[DIR_LSB +: NUM_PINS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    wms_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in[1:0]),
        .dout (sync_pins)
    );

    wms_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (regs_q.mode),
        .dat_in    (sync_pins[PIN_DAT]),
        .clk_in    (sync_pins[PIN_CLK]),
        .data_wr   (wr_data),
        .data_wdata(reg_wdata),
        .stat_wr   (wr_stat),
        .clr_start (reg_wdata[START_BIT]),
        .clr_ovf   (reg_wdata[OVF_BIT]),
        .cnt_wdata (reg_wdata[CNT_W-1:0]),
        .shreg     (shreg),
        .cnt       (cnt),
        .start_flag(start_flag),
        .ovf_flag  (ovf_flag)
    );

    assign hold = (regs_q.mode[1] & start_flag) | ((regs_q.mode == WM_TWO_OVF) & ovf_flag);

    wms_pad u_pad (
        .mode      (regs_q.mode),
        .port      (regs_q.port),
        .dir       (regs_q.dir),
        .sh_msb    (shreg[DATA_W-1]),
        .hold      (hold),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pullup(pad_pullup)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata[MODE_LSB +: 2] = regs_q.mode;
            ADDR_DATA: reg_rdata = shreg;
            ADDR_STAT: reg_rdata = {start_flag, ovf_flag, {STAT_PAD{1'b0}}, cnt};
            default: begin
                reg_rdata[0 +: NUM_PINS]       = regs_q.port;
                reg_rdata[DIR_LSB +: NUM_PINS] = regs_q.dir;
            end
        endcase
    end

    assert_scl_hold_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.mode[1] && regs_q.dir[PIN_CLK] && start_flag) |-> pad_oe[PIN_CLK]);

    assert_scl_hold_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.mode == WM_TWO_OVF && regs_q.dir[PIN_CLK] && ovf_flag) |-> pad_oe[PIN_CLK]);

    assert_pullups_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.mode[1] |-> (pad_pullup[1:0] == 2'b00));

    assert_strobe_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[STROBE_BIT]) |=> (regs_q.port[PIN_CLK] != $past(regs_q.port[PIN_CLK])));
endmodule

// File: tb/wire_mode_shifter_tb.sv
module wire_mode_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [2:0] pad_in = 3'b111;
    logic [2:0] pad_out, pad_oe, pad_pullup;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wire_mode_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup)
    );

    // {mode[1:0], port[2:0], dir[2:0], data[7:0], out[2:0], oe[2:0], pu[2:0]}
    localparam logic [24:0] VEC [10] = '{
        {2'b00, 3'b101, 3'b011, 8'h80, 3'b101, 3'b011, 3'b100},
        {2'b00, 3'b010, 3'b000, 8'h00, 3'b010, 3'b000, 3'b010},
        {2'b01, 3'b000, 3'b100, 8'h80, 3'b100, 3'b100, 3'b000},
        {2'b01, 3'b111, 3'b111, 8'h00, 3'b011, 3'b111, 3'b000},
        {2'b01, 3'b011, 3'b000, 8'h80, 3'b111, 3'b000, 3'b011},
        {2'b10, 3'b111, 3'b111, 8'h80, 3'b100, 3'b100, 3'b000},
        {2'b10, 3'b111, 3'b111, 8'h00, 3'b100, 3'b101, 3'b000},
        {2'b10, 3'b110, 3'b011, 8'h80, 3'b100, 3'b001, 3'b100},
        {2'b11, 3'b001, 3'b010, 8'h80, 3'b000, 3'b010, 3'b000},
        {2'b11, 3'b101, 3'b111, 8'h80, 3'b100, 3'b110, 3'b000}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pin(input int idx, input logic v);
        @(negedge clk);
        pad_in[idx] = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            chk("R1 reset reg", r, 8'h00);
        end
        chk("R1 reset oe", {5'b0, pad_oe}, 8'h00);
        chk("R1 reset pullup", {5'b0, pad_pullup}, 8'h00);

        // R2 R3 R4 R5 pin mapping table
        foreach (VEC[i]) begin
            wr(2'd0, {2'b00, VEC[i][24:23], 4'b0000});
            wr(2'd3, {1'b0, VEC[i][19:17], 1'b0, VEC[i][22:20]});
            wr(2'd1, VEC[i][16:9]);
            @(negedge clk);
            chk("R2/R3/R4/R5 vector out", {5'b0, pad_out}, {5'b0, VEC[i][8:6]});
            chk("R2/R3/R4/R5 vector oe", {5'b0, pad_oe}, {5'b0, VEC[i][5:3]});
            chk("R2/R3/R4/R5 vector pullup", {5'b0, pad_pullup}, {5'b0, VEC[i][2:0]});
        end

        // R8 R7 shift a byte MSB first in mode 01
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        for (int b = 7; b >= 0; b--) begin
            pin(1, 1'b0);
            pin(0, b[0] ? 1'b1 : 1'b0);
            pin(0, (8'hA5 >> b) & 1);
            pin(1, 1'b1);
        end
        rd(2'd1, r); chk("R8 shifted byte", r, 8'hA5);
        rd(2'd2, r); chk("R7 wrap after 16 edges", r, 8'h40);

        // R5 overflow hold only in mode 11
        wr(2'd3, 8'h22);
        wr(2'd0, 8'h20);
        @(negedge clk);
        chk("R5 no ovf hold in mode 10", {5'b0, pad_oe}, 8'h00);
        wr(2'd0, 8'h30);
        @(negedge clk);
        chk("R5 ovf hold in mode 11", {5'b0, pad_oe}, 8'h02);
        wr(2'd2, 8'h40);
        @(negedge clk);
        rd(2'd2, r); chk("R9 ovf cleared", r, 8'h00);
        chk("R5 released after clear", {5'b0, pad_oe}, 8'h00);

        // R6 start condition in mode 10 holds SCL
        wr(2'd0, 8'h20);
        pin(0, 1'b0);
        rd(2'd2, r); chk("R6 start flag set", r, 8'h80);
        chk("R5 start hold", {5'b0, pad_oe}, 8'h02);
        wr(2'd2, 8'h00);
        rd(2'd2, r); chk("R9 zero write keeps flag", r, 8'h80);
        wr(2'd2, 8'h80);
        @(negedge clk);
        rd(2'd2, r); chk("R9 start cleared", r, 8'h00);
        chk("R5 start hold released", {5'b0, pad_oe}, 8'h00);
        pin(0, 1'b1);

        // R2 mode 00 ignores edges and start conditions
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h3C);
        wr(2'd2, 8'h00);
        pin(1, 1'b0);
        pin(1, 1'b1);
        pin(0, 1'b0);
        pin(0, 1'b1);
        rd(2'd1, r); chk("R2 data frozen in mode 00", r, 8'h3C);
        rd(2'd2, r); chk("R2 no count or start in mode 00", r, 8'h00);

        // R7 counter preload to 15 then one edge wraps
        wr(2'd0, 8'h10);
        wr(2'd2, 8'h0F);
        rd(2'd2, r); chk("R7 counter load", r, 8'h0F);
        pin(1, 1'b0);
        rd(2'd2, r); chk("R7 single edge wrap", r, 8'h40);
        wr(2'd2, 8'h40);
        pin(1, 1'b1);
        rd(2'd2, r); chk("R7 count after clear", r, 8'h01);

        // R10 strobe toggles clock port bit
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h01);
        rd(2'd3, r); chk("R10 strobe toggles port1", r, 8'h02);
        rd(2'd0, r); chk("R10 strobe reads zero", r, 8'h00);
        wr(2'd0, 8'h01);
        rd(2'd3, r); chk("R10 strobe toggles back", r, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule